// File: doc/BRIEF.md
# Dual-Rail Instruction Memory Bridge

This block sits between the instruction-fetch stage of a dual-rail, four-phase return-to-zero core and a pair of ordinary single-rail byte-wide memories. On the address side, each address bit arrives as a true/false rail pair. The true rails go straight out as the memory address. A completion tree watches every pair and produces a memory strobe. The strobe rises only once every pair carries a valid code word. It falls only once every rail has returned to zero. The fetch stage's active-high enable is inverted to drive the memory's active-low enable.

On the data side, the bridge joins the two memory bytes into one instruction word and re-encodes it as dual-rail. This happens only while the strobe is high. While the strobe is low, every data rail is held at zero, which forms the spacer that ends the four-phase cycle. The completion element is a hysteresis state bit clocked by the system clock and cleared by reset. It changes only when all pairs agree, and otherwise it keeps its value.

Top module: `dr_imem_bridge`

## Requirements
- R1: `mem_addr_o` always equals `addr_t_i`, the true rail of each address pair.
- R2: `mem_en_no` is always the complement of `fetch_en_i`.
- R3: `mem_strobe_o` goes high on the first clock edge at which every address pair has exactly one rail high (valid code: true=1/false=0 or true=0/false=1). It does not rise while any pair is 00.
- R4: `mem_strobe_o` goes low on the first clock edge at which every address rail is 0. It stays high while only some pairs have returned to 00.
- R5: A pair with both rails high counts as neither valid nor empty. While such a pair is present, the strobe keeps its value.
- R6: While `rst_ni` is low, the strobe is 0.
- R7: The instruction word is `{mem_hi_i, mem_lo_i}`. The first memory supplies bits [15:8] and the second memory supplies bits [7:0].
- R8: While the strobe is high, `instr_t_o` equals the word and `instr_f_o` equals its bitwise complement.
- R9: While the strobe is low, every bit of `instr_t_o` and `instr_f_o` is 0, whatever the memory bytes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the completion state bit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_t_i | input | ADDR_W | True rails of the dual-rail address |
| addr_f_i | input | ADDR_W | False rails of the dual-rail address |
| fetch_en_i | input | 1 | Active-high enable from the fetch stage |
| mem_addr_o | output | ADDR_W | Single-rail address to both memories |
| mem_en_no | output | 1 | Active-low memory enable |
| mem_strobe_o | output | 1 | Completion strobe qualifying the address |
| mem_hi_i | input | BYTE_W | Byte from the first memory |
| mem_lo_i | input | BYTE_W | Byte from the second memory |
| instr_t_o | output | 2*BYTE_W | True rails of the instruction word |
| instr_f_o | output | 2*BYTE_W | False rails of the instruction word |

## Verification
The hardest situations to reach are the ones where the completion state must hold its value. One is a half-filled address, where some pairs are valid and others are still 00. Another is a half-drained address, where some pairs have returned to 00 and others remain valid. A third is an illegal 11 pair. The bench brings each of these about by driving the true and false rail vectors separately instead of as one value. It lets a clock edge pass, checks that the strobe has not moved, and then completes or clears the remaining pairs so it can see the transition on the next edge.

// File: rtl/dr_bridge_pkg.sv
package dr_bridge_pkg;
   // Smaller of two integers, used to size the last partial group.
   function automatic int dr_min(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // Number of groups needed to cover a width.
   function automatic int dr_groups(input int width, input int grp);
      return (width + grp - 1) / grp;
   endfunction

   // Completion flags reported by a group of rail pairs.
   typedef struct packed {
      logic all_valid;
      logic all_empty;
   } dr_done_t;
endpackage

// File: rtl/dr_pair_group.sv
module dr_pair_group #(
   parameter int GW = 4
) (
   input  logic [GW-1:0] rail_t_i,
   input  logic [GW-1:0] rail_f_i,
   output dr_bridge_pkg::dr_done_t done_o
);
   if (GW < 1) begin : g_bad_gw
      $error("dr_pair_group: GW must be at least 1");
   end

   logic [GW-1:0] pair_valid;
   logic [GW-1:0] pair_empty;

   for (genvar b = 0; b < GW; b++) begin : g_pair
      // exactly one rail high marks a code word, both low mark a spacer
      assign pair_valid[b] = rail_t_i[b] ^ rail_f_i[b];
      assign pair_empty[b] = ~(rail_t_i[b] | rail_f_i[b]);
   end

   assign done_o.all_valid = &pair_valid;
   assign done_o.all_empty = &pair_empty;
endmodule

// File: rtl/dr_completion_tree.sv
module dr_completion_tree #(
   parameter int W       = 8,
   parameter int GROUP_W = 4
) (
   input  logic [W-1:0] rail_t_i,
   input  logic [W-1:0] rail_f_i,
   output logic         set_o,
   output logic         clr_o
);
   import dr_bridge_pkg::*;

   localparam int NGRP = dr_groups(W, GROUP_W);

   if (GROUP_W < 1) begin : g_bad_grp
      $error("dr_completion_tree: GROUP_W must be at least 1");
   end

   logic [NGRP-1:0] grp_valid;
   logic [NGRP-1:0] grp_empty;

   if (GROUP_W >= W) begin : g_flat
      dr_done_t flat_done;
      dr_pair_group #(.GW(W)) u_grp (
         .rail_t_i (rail_t_i),
         .rail_f_i (rail_f_i),
         .done_o   (flat_done)
      );
      assign grp_valid = flat_done.all_valid;
      assign grp_empty = flat_done.all_empty;
   end else begin : g_tree
      for (genvar g = 0; g < NGRP; g++) begin : g_leaf
         localparam int LO = g * GROUP_W;
         localparam int GW = dr_min(LO + GROUP_W, W) - LO;
         dr_done_t leaf_done;
         dr_pair_group #(.GW(GW)) u_grp (
            .rail_t_i (rail_t_i[LO +: GW]),
            .rail_f_i (rail_f_i[LO +: GW]),
            .done_o   (leaf_done)
         );
         assign grp_valid[g] = leaf_done.all_valid;
         assign grp_empty[g] = leaf_done.all_empty;
      end
   end

   // root of the tree: every group must agree
   assign set_o = &grp_valid;
   assign clr_o = &grp_empty;
endmodule

// File: rtl/dr_c_hold.sv
module dr_c_hold (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic state_q;

   // hysteresis: move only when all inputs agree, otherwise keep
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= 1'b0;
      end else if (set_i) begin
         state_q <= 1'b1;
      end else if (clr_i) begin
         state_q <= 1'b0;
      end
   end

   assign q_o = state_q;
endmodule

// File: rtl/dr_word_encode.sv
module dr_word_encode #(
   parameter int BYTE_W = 8
) (
   input  logic                  strobe_i,
   input  logic [BYTE_W-1:0]     hi_i,
   input  logic [BYTE_W-1:0]     lo_i,
   output logic [2*BYTE_W-1:0]   word_t_o,
   output logic [2*BYTE_W-1:0]   word_f_o
);
   localparam int WW = 2 * BYTE_W;

   logic [WW-1:0] word;
   assign word = {hi_i, lo_i};

   for (genvar b = 0; b < WW; b++) begin : g_bit
      // strobe low forces the spacer on both rails
      assign word_t_o[b] = strobe_i &  word[b];
      assign word_f_o[b] = strobe_i & ~word[b];
   end
endmodule

// File: rtl/dr_imem_bridge.sv
module dr_imem_bridge #(
   parameter int ADDR_W  = 8,
   parameter int BYTE_W  = 8,
   parameter int GROUP_W = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [ADDR_W-1:0]     addr_t_i,
   input  logic [ADDR_W-1:0]     addr_f_i,
   input  logic                  fetch_en_i,
   output logic [ADDR_W-1:0]     mem_addr_o,
   output logic                  mem_en_no,
   output logic                  mem_strobe_o,
   input  logic [BYTE_W-1:0]     mem_hi_i,
   input  logic [BYTE_W-1:0]     mem_lo_i,
   output logic [2*BYTE_W-1:0]   instr_t_o,
   output logic [2*BYTE_W-1:0]   instr_f_o
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("dr_imem_bridge: ADDR_W must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("dr_imem_bridge: BYTE_W must be at least 1");
   end

   logic set_w;
   logic clr_w;
   logic strobe_w;

   assign mem_addr_o = addr_t_i;
   assign mem_en_no  = ~fetch_en_i;

   dr_completion_tree #(.W(ADDR_W), .GROUP_W(GROUP_W)) u_tree (
      .rail_t_i (addr_t_i),
      .rail_f_i (addr_f_i),
      .set_o    (set_w),
      .clr_o    (clr_w)
   );

   dr_c_hold u_cel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_w),
      .clr_i  (clr_w),
      .q_o    (strobe_w)
   );

   assign mem_strobe_o = strobe_w;

   dr_word_encode #(.BYTE_W(BYTE_W)) u_enc (
      .strobe_i (strobe_w),
      .hi_i     (mem_hi_i),
      .lo_i     (mem_lo_i),
      .word_t_o (instr_t_o),
      .word_f_o (instr_f_o)
   );
endmodule

// File: rtl/dr_imem_bridge_chk.sv
module dr_imem_bridge_chk #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 8
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [ADDR_W-1:0]   addr_t_i,
   input logic [ADDR_W-1:0]   addr_f_i,
   input logic                fetch_en_i,
   input logic [ADDR_W-1:0]   mem_addr_o,
   input logic                mem_en_no,
   input logic                mem_strobe_o,
   input logic [BYTE_W-1:0]   mem_hi_i,
   input logic [BYTE_W-1:0]   mem_lo_i,
   input logic [2*BYTE_W-1:0] instr_t_o,
   input logic [2*BYTE_W-1:0] instr_f_o
);
   logic full_a, zero_a, bad_a;
   assign full_a = &(addr_t_i ^ addr_f_i);
   assign zero_a = ~|(addr_t_i | addr_f_i);
   assign bad_a  = |(addr_t_i & addr_f_i);

   assert_addr_true_rail_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_addr_o == addr_t_i);
   assert_enable_polarity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_en_no != fetch_en_i);
   assert_set_on_complete_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_a |=> mem_strobe_o);
   assert_rise_after_complete_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mem_strobe_o) |-> $past(full_a));
   assert_clear_on_spacer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_a |=> !mem_strobe_o);
   assert_fall_after_spacer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mem_strobe_o) |-> $past(zero_a));
   assert_hold_on_illegal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_a |=> $stable(mem_strobe_o));
   assert_reset_low_R6: assert property (@(posedge clk_i)
      !rst_ni |=> !mem_strobe_o);
   assert_word_rails_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_strobe_o |-> (instr_t_o == {mem_hi_i, mem_lo_i}) && (&(instr_t_o ^ instr_f_o)));
   assert_spacer_rails_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_strobe_o |-> (instr_t_o == '0) && (instr_f_o == '0));
endmodule

bind dr_imem_bridge dr_imem_bridge_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .addr_t_i     (addr_t_i),
   .addr_f_i     (addr_f_i),
   .fetch_en_i   (fetch_en_i),
   .mem_addr_o   (mem_addr_o),
   .mem_en_no    (mem_en_no),
   .mem_strobe_o (mem_strobe_o),
   .mem_hi_i     (mem_hi_i),
   .mem_lo_i     (mem_lo_i),
   .instr_t_o    (instr_t_o),
   .instr_f_o    (instr_f_o)
);

// File: tb/dr_imem_bridge_tb_top.sv
module dr_imem_bridge_tb_top;
   localparam int AW = 8;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] a_t = '0, a_f = '0;
   logic          en = 1'b0;
   logic [BW-1:0] hi = '0, lo = '0;
   logic [AW-1:0] m_addr;
   logic          m_en_n, strobe;
   logic [2*BW-1:0] i_t, i_f;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dr_imem_bridge #(.ADDR_W(AW), .BYTE_W(BW), .GROUP_W(3)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_t_i(a_t), .addr_f_i(a_f),
      .fetch_en_i(en), .mem_addr_o(m_addr), .mem_en_no(m_en_n),
      .mem_strobe_o(strobe), .mem_hi_i(hi), .mem_lo_i(lo),
      .instr_t_o(i_t), .instr_f_o(i_f));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive after falling edge, let one rising edge pass, sample at next falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put_addr(input logic [AW-1:0] v);
      a_t = v;
      a_f = ~v;
   endtask

   task automatic t_reset();
      hi = 8'hA5; lo = 8'h3C;
      put_addr(8'h5A);
      @(negedge clk);
      check("R6 strobe in reset", 32'(strobe), 32'd0);
      check("R9 true rails in reset", 32'(i_t), 32'd0);
      check("R9 false rails in reset", 32'(i_f), 32'd0);
      a_t = '0; a_f = '0;
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_enable();
      en = 1'b1; #1;
      check("R2 enable high", 32'(m_en_n), 32'd0);
      en = 1'b0; #1;
      check("R2 enable low", 32'(m_en_n), 32'd1);
   endtask

   task automatic t_addr();
      foreach (a_t[k]) begin
         put_addr(AW'(1) << k); #1;
         check("R1 true rail address", 32'(m_addr), 32'(AW'(1) << k));
      end
      a_t = '0; a_f = '0;
      step();
   endtask

   task automatic t_fill();
      a_t = 8'h0C; a_f = 8'h30;
      step();
      check("R3 partial fill keeps strobe low", 32'(strobe), 32'd0);
      a_t = 8'h8C; a_f = 8'h73;
      #1;
      check("R3 no rise before edge", 32'(strobe), 32'd0);
      step();
      check("R3 rise after complete", 32'(strobe), 32'd1);
   endtask

   task automatic t_data();
      hi = 8'h12; lo = 8'hEF; #1;
      check("R7 R8 true rails", 32'(i_t), 32'h12EF);
      check("R8 false rails", 32'(i_f), 32'hED10);
      hi = 8'hFF; lo = 8'h00; #1;
      check("R7 high byte from first memory", 32'(i_t), 32'hFF00);
      check("R8 false rails", 32'(i_f), 32'h00FF);
      hi = 8'h0F; lo = 8'hF0; #1;
      check("R7 R8 true rails", 32'(i_t), 32'h0FF0);
   endtask

   task automatic t_drain();
      a_t = 8'h80; a_f = 8'h00;
      step();
      check("R4 partial drain keeps strobe high", 32'(strobe), 32'd1);
      a_t = '0; a_f = '0;
      step();
      check("R4 fall after all rails zero", 32'(strobe), 32'd0);
      hi = 8'hC3; lo = 8'h96; #1;
      check("R9 true rails spacer", 32'(i_t), 32'd0);
      check("R9 false rails spacer", 32'(i_f), 32'd0);
   endtask

   task automatic t_illegal();
      put_addr(8'h55); a_f[2] = 1'b1; a_t[2] = 1'b1;
      step();
      check("R5 illegal pair blocks rise", 32'(strobe), 32'd0);
      put_addr(8'h55);
      step();
      check("R5 rise once pair legal", 32'(strobe), 32'd1);
      a_t = 8'h01; a_f = 8'h01;
      step();
      check("R5 illegal pair blocks fall", 32'(strobe), 32'd1);
      a_t = '0; a_f = '0;
      step();
      check("R5 fall once spacer", 32'(strobe), 32'd0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_enable();
      t_addr();
      t_fill();
      t_data();
      t_drain();
      t_illegal();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule